// File: doc/BRIEF.md
# Embedded-Sync to Discrete-Sync Video Converter

This block takes a progressive 16-bit YCbCr 4:2:2 stream whose line and frame timing is carried inside the data as start-of-active-video (SAV) and end-of-active-video (EAV) codes. It decodes those codes and re-emits the picture on a generic parallel interface with separate horizontal sync, vertical sync and field-identity outputs. A downstream capture engine can then take timing from dedicated pins. Every sync edge follows a decoded code, so the output stays locked to the input. No independent timing generator is involved.

On the way through, the block thins the input frame rate (nominally 60 fps) to either half rate or five-twelfths rate, which gives 30 or 25 fps. It can also trim the active picture to a rectangular window. Pixel data is qualified by the sync pins: a word is meaningful only when both syncs are low. At all other times the data bus is driven to zero. Dropped frames and pixels outside the window never reach the output.

Top module: `vid_sync_split`

## Requirements
- R1: A timing code is the luma-lane sequence (luma = `vid_i[15:8]`) 0xFF, 0x00, 0x00 followed by a word XY with bit 7 = 1, F = bit 6, V = bit 5, H = bit 4 (H = 1 for EAV, H = 0 for SAV). Bits 3..0 must equal V^H, F^H, F^V and F^V^H. A candidate that fails this check is treated as ordinary data and changes no sync state.
- R2: Only words that follow an SAV with V = 0 and precede the next EAV are pixel words. No word of a code (preamble or XY) is ever output as valid data.
- R3: A word is valid when `hsync_o` and `vsync_o` are both low. While either sync is high, `vid_o` is zero.
- R4: A valid output word equals the input word sampled three rising edges earlier.
- R5: Frames are numbered k = 0, 1, 2, ... from reset. k advances at each frame start, which is a valid code with V = 0 following a valid code with V = 1, and it wraps modulo 12. In half-rate mode (`slow_rate_i` = 0), frame k is kept when k is even.
- R6: In slow mode (`slow_rate_i` = 1), frame k is kept when (5·k mod 12) < 5, which keeps 5 frames of every 12. A dropped frame yields no valid word.
- R7: In a kept frame, active line n (0-based count of SAVs with V = 0 since frame start) and pixel p (0-based position after its SAV) are output only if n is within [`win_line_first_i`, `win_line_last_i`] and p is within [`win_pix_first_i`, `win_pix_last_i`]. Both ranges are inclusive.
- R8: The window inputs and the rate select are sampled only at frame start. A change during a frame takes effect from the next frame.
- R9: `fid_o` takes the F bit of the code that starts the frame and holds it until the next frame start. A progressive stream with F = 0 therefore keeps it at 0.
- R10: After reset, `hsync_o` and `vsync_o` are high, and `vid_o` and `fid_o` are zero. No word is valid until a frame start has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_i | input | 16 | Input word, luma in [15:8], chroma in [7:0], with embedded codes |
| slow_rate_i | input | 1 | Rate select: 0 keeps 1 frame in 2, 1 keeps 5 frames in 12 |
| win_line_first_i | input | LINE_W | First active line kept (inclusive) |
| win_line_last_i | input | LINE_W | Last active line kept (inclusive) |
| win_pix_first_i | input | PIX_W | First pixel kept in a line (inclusive) |
| win_pix_last_i | input | PIX_W | Last pixel kept in a line (inclusive) |
| vid_o | output | 16 | Output word, zero when not valid |
| hsync_o | output | 1 | High outside the valid pixels of a line |
| vsync_o | output | 1 | High outside kept, in-window lines |
| fid_o | output | 1 | Field identity taken from F at frame start |

## Verification
The bench builds the converter with PIX_W = 6 and LINE_W = 5, and keeps the default decimation period of 12 with 5 kept frames in slow mode. The synthetic picture is 12 pixels by 6 active lines with 2 blanking lines, which makes a frame about 190 cycles long. Complete 12-frame decimation cycles in both rate modes, several crop windows (including a single pixel), a window change in mid-frame, a corrupted SAV and an odd-field frame therefore all fit in a short run. Every valid word is compared against the input three edges earlier, so leakage of code words and lane mix-ups show up directly.

// File: rtl/vss_pkg.sv
package vss_pkg;

    localparam int unsigned BUS_W   = 16;
    localparam int unsigned PRE_LEN = 3;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } xy_t;

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic             pix;
        logic             line;
    } pipe_t;

    function automatic logic [3:0] xy_prot(input xy_t c);
        return {c.v ^ c.h, c.f ^ c.h, c.f ^ c.v, c.f ^ c.v ^ c.h};
    endfunction

endpackage

// File: rtl/vss_code_det.sv
module vss_code_det
    import vss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] vid_i,
    output logic             hit_o,
    output xy_t              xy_o
);
    typedef struct packed {
        logic [7:0] b0;
        logic [7:0] b1;
        logic [7:0] b2;
    } hist_t;

    hist_t hs_d, hs_q;
    logic [7:0] luma;
    logic       pre_ok;

    always_comb begin
        luma       = vid_i[BUS_W-1 -: 8];
        hs_d.b0    = luma;
        hs_d.b1    = hs_q.b0;
        hs_d.b2    = hs_q.b1;
        xy_o.f     = luma[6];
        xy_o.v     = luma[5];
        xy_o.h     = luma[4];
        pre_ok     = (hs_q.b2 == 8'hFF) && (hs_q.b1 == 8'h00) && (hs_q.b0 == 8'h00);
        hit_o      = pre_ok && luma[7] && (luma[3:0] == xy_prot(xy_o));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '{b0: 8'h10, b1: 8'h10, b2: 8'h10};
        else        hs_q <= hs_d;
    end

    // R1
    preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ($past(vid_i[15:8], 1) == 8'h00 && $past(vid_i[15:8], 2) == 8'h00
                   && $past(vid_i[15:8], 3) == 8'hFF));

endmodule

// File: rtl/vss_frame_dec.sv
module vss_frame_dec #(
    parameter int unsigned PERIOD    = 12,
    parameter int unsigned SLOW_KEEP = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fstart_i,
    input  logic slow_i,
    output logic keep_o,
    output logic keep_nxt_o
);
    localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             keep;
    } dec_t;

    dec_t dc_d, dc_q;
    logic pred;
    int unsigned prod;

    always_comb begin
        prod = (SLOW_KEEP * int'(dc_q.cnt)) % PERIOD;
        pred = slow_i ? (prod < SLOW_KEEP) : !dc_q.cnt[0];
        dc_d = dc_q;
        if (fstart_i) begin
            dc_d.keep = pred;
            dc_d.cnt  = (int'(dc_q.cnt) == PERIOD - 1) ? '0 : dc_q.cnt + 1'b1;
        end
        keep_o     = dc_q.keep;
        keep_nxt_o = dc_d.keep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dc_q <= '0;
        else        dc_q <= dc_d;
    end

    // R5
    odd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fstart_i && !slow_i && dc_q.cnt[0]) |=> !keep_o);

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dc_q.cnt) < PERIOD);

endmodule

// File: rtl/vss_pipe.sv
module vss_pipe
    import vss_pkg::*;
#(
    parameter int unsigned DEPTH = PRE_LEN
) (
    input  logic  clk,
    input  logic  rst_n,
    input  pipe_t ent_i,
    input  logic  kill_i,
    output pipe_t ent_o
);
    pipe_t stg_d [DEPTH];
    pipe_t stg_q [DEPTH];

    always_comb begin
        stg_d[0] = ent_i;
        for (int i = 1; i < DEPTH; i++) begin
            stg_d[i] = stg_q[i-1];
            if (kill_i) stg_d[i].pix = 1'b0;
        end
        ent_o = stg_q[DEPTH-1];
        if (kill_i) ent_o.pix = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) stg_q[i] <= stg_d[i];
        end
    end

endmodule

// File: rtl/vid_sync_split.sv
module vid_sync_split
    import vss_pkg::*;
#(
    parameter int unsigned PIX_W      = 11,
    parameter int unsigned LINE_W     = 11,
    parameter int unsigned DEC_PERIOD = 12,
    parameter int unsigned SLOW_KEEP  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       vid_i,
    input  logic              slow_rate_i,
    input  logic [LINE_W-1:0] win_line_first_i,
    input  logic [LINE_W-1:0] win_line_last_i,
    input  logic [PIX_W-1:0]  win_pix_first_i,
    input  logic [PIX_W-1:0]  win_pix_last_i,
    output logic [15:0]       vid_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              fid_o
);
    typedef struct packed {
        logic [LINE_W-1:0] line_first;
        logic [LINE_W-1:0] line_last;
        logic [PIX_W-1:0]  pix_first;
        logic [PIX_W-1:0]  pix_last;
    } win_t;

    typedef struct packed {
        logic              v;
        logic              in_line;
        logic              line_ok;
        logic [LINE_W-1:0] line_cnt;
        logic [PIX_W-1:0]  pix_cnt;
        win_t              win;
        logic              fid;
        logic [BUS_W-1:0]  dout;
        logic              hs;
        logic              vs;
    } st_t;

    st_t   st_d, st_q;
    xy_t   xy;
    logic  hit, fstart, keep_cur, keep_nxt, col_ok, keep_use;
    win_t  win_in, win_use;
    logic [LINE_W-1:0] line_base;
    pipe_t ent_in, ent_out;

    vss_code_det u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .vid_i (vid_i),
        .hit_o (hit),
        .xy_o  (xy)
    );

    vss_frame_dec #(.PERIOD(DEC_PERIOD), .SLOW_KEEP(SLOW_KEEP)) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .fstart_i   (fstart),
        .slow_i     (slow_rate_i),
        .keep_o     (keep_cur),
        .keep_nxt_o (keep_nxt)
    );

    vss_pipe #(.DEPTH(PRE_LEN)) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .ent_i  (ent_in),
        .kill_i (hit),
        .ent_o  (ent_out)
    );

    always_comb begin
        st_d      = st_q;
        win_in    = '{line_first: win_line_first_i, line_last: win_line_last_i,
                      pix_first: win_pix_first_i, pix_last: win_pix_last_i};
        fstart    = hit && !xy.v && st_q.v;
        win_use   = fstart ? win_in : st_q.win;
        keep_use  = fstart ? keep_nxt : keep_cur;
        line_base = fstart ? '0 : st_q.line_cnt;
        col_ok    = (st_q.pix_cnt >= st_q.win.pix_first) && (st_q.pix_cnt <= st_q.win.pix_last);

        ent_in.data = vid_i;
        ent_in.pix  = st_q.in_line && !hit && st_q.line_ok && col_ok;
        ent_in.line = st_q.line_ok;

        if (st_q.in_line && !hit && st_q.pix_cnt != '1)
            st_d.pix_cnt = st_q.pix_cnt + 1'b1;

        if (fstart) begin
            st_d.win      = win_in;
            st_d.fid      = xy.f;
            st_d.line_cnt = '0;
        end

        if (hit) begin
            st_d.v = xy.v;
            if (xy.h) begin
                st_d.in_line = 1'b0;
            end else begin
                st_d.in_line = 1'b1;
                st_d.pix_cnt = '0;
                if (!xy.v) begin
                    st_d.line_ok  = keep_use && (line_base >= win_use.line_first)
                                    && (line_base <= win_use.line_last);
                    st_d.line_cnt = (line_base == '1) ? line_base : line_base + 1'b1;
                end else begin
                    st_d.line_ok  = 1'b0;
                end
            end
        end

        st_d.dout = ent_out.pix ? ent_out.data : '0;
        st_d.hs   = !ent_out.pix;
        st_d.vs   = !ent_out.line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.hs <= 1'b1;
            st_q.vs <= 1'b1;
        end else begin
            st_q    <= st_d;
        end
    end

    assign vid_o   = st_q.dout;
    assign hsync_o = st_q.hs;
    assign vsync_o = st_q.vs;
    assign fid_o   = st_q.fid;

    // R3
    hv_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_o |-> !vsync_o);

    // R9
    fid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fstart |=> $stable(fid_o));

    // R8
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fstart |=> $stable(st_q.win));

endmodule

// File: tb/vid_sync_split_tb.sv
`timescale 1ns/1ps
module vid_sync_split_tb;
    localparam int ACT_P = 12;
    localparam int ACT_L = 6;
    localparam int VBL   = 2;
    localparam int HBL   = 4;
    localparam logic [15:0] BLANK = 16'h1080;
    // fields (hex digits): mode, line_first, line_last, pix_first, pix_last, kept per 12
    localparam int NVEC = 5;
    localparam logic [23:0] VEC [NVEC] = '{24'h0_0_5_0_B_6, 24'h1_0_5_0_B_5,
                                           24'h0_1_3_2_9_6, 24'h1_5_5_B_B_5,
                                           24'h0_0_0_0_0_6};

    logic clk = 1'b0, rst_n = 1'b0;
    logic [15:0] vid_i = BLANK;
    logic slow = 1'b0;
    logic [4:0] lf = '0, ll = 5'd5;
    logic [5:0] pf = '0, pl = 6'd11;
    logic [15:0] vid_o;
    logic hsync_o, vsync_o, fid_o;

    int n_chk = 0, n_fail = 0, k = 0, cyc = 0;
    int valid_cnt, bad_blank, lat_err, fid_tog;
    logic [15:0] first_w, last_w, hist [16];
    logic got_first, prev_fid, done = 1'b0;

    always #2 clk = ~clk;

    vid_sync_split #(.PIX_W(6), .LINE_W(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .vid_i(vid_i), .slow_rate_i(slow),
        .win_line_first_i(lf), .win_line_last_i(ll),
        .win_pix_first_i(pf), .win_pix_last_i(pl),
        .vid_o(vid_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .fid_o(fid_o));

    always @(posedge clk) begin
        cyc = cyc + 1;
        hist[cyc % 16] = vid_i;
    end

    always @(negedge clk) if (rst_n) begin
        if ((hsync_o || vsync_o) && vid_o != 16'h0) bad_blank++;
        if (!hsync_o && !vsync_o) begin
            valid_cnt++;
            if (vid_o != hist[(cyc - 3) % 16]) lat_err++;
            if (!got_first) first_w = vid_o;
            got_first = 1'b1;
            last_w = vid_o;
        end
        if (fid_o != prev_fid) fid_tog++;
        prev_fid = fid_o;
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] xy(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    task automatic word(input logic [15:0] w);
        @(negedge clk) vid_i = w;
    endtask

    task automatic code(input logic [7:0] c);
        word(16'hFFFF); word(16'h0000); word(16'h0000); word({c, c});
    endtask

    task automatic send_line(input logic v, input logic f, input logic bad_sav, input int ln);
        logic [7:0] s;
        code(xy(f, v, 1'b1));
        for (int i = 0; i < HBL; i++) word(BLANK);
        s = xy(f, v, 1'b0);
        if (bad_sav) s[0] = ~s[0];
        code(s);
        for (int p = 0; p < ACT_P; p++)
            word(v ? BLANK : {8'h40 + 8'(p), 8'h80 + 8'(ln)});
    endtask

    task automatic send_frame(input logic f, input int bad_ln, input int chg_ln,
                              input logic [4:0] nlf, input logic [4:0] nll,
                              input logic [5:0] npf, input logic [5:0] npl);
        @(negedge clk);
        valid_cnt = 0; bad_blank = 0; lat_err = 0; fid_tog = 0; got_first = 1'b0;
        first_w = '0; last_w = '0;
        for (int l = 0; l < ACT_L; l++) begin
            if (l == chg_ln) begin lf = nlf; ll = nll; pf = npf; pl = npl; end
            send_line(1'b0, f, l == bad_ln, l);
        end
        for (int l = 0; l < VBL; l++) send_line(1'b1, f, 1'b0, 0);
        k = (k + 1) % 12;
    endtask

    function automatic logic keep_of(input int kk, input logic sl);
        return sl ? (((5 * kk) % 12) < 5) : (kk % 2 == 0);
    endfunction

    task automatic align_even();
        if (k % 2 != 0) send_frame(1'b0, -1, -1, 0, 0, 0, 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        prev_fid = 1'b0;
        valid_cnt = 0; bad_blank = 0; lat_err = 0; fid_tog = 0; got_first = 1'b0;
        repeat (4) @(negedge clk);
        // R10 reset state
        chk(hsync_o == 1'b1 && vsync_o == 1'b1, "R10", "syncs in reset", {hsync_o, vsync_o}, 3);
        chk(vid_o == 16'h0, "R10", "data in reset", vid_o, 0);
        chk(fid_o == 1'b0, "R10", "fid in reset", fid_o, 0);
        @(negedge clk) rst_n = 1'b1;
        send_line(1'b1, 1'b0, 1'b0, 0);
        repeat (4) @(negedge clk);
        // R10 nothing valid before a frame start
        chk(valid_cnt == 0, "R10", "valid before frame", valid_cnt, 0);

        // table walk: R5 R6 R7 R2 R3 R4
        for (int e = 0; e < NVEC; e++) begin
            logic [23:0] v;
            int kept, exp_n;
            v = VEC[e];
            slow = v[20];
            lf = 5'(v[19:16]); ll = 5'(v[15:12]); pf = 6'(v[11:8]); pl = 6'(v[7:4]);
            exp_n = (int'(ll) - int'(lf) + 1) * (int'(pl) - int'(pf) + 1);
            kept = 0;
            for (int fr = 0; fr < 12; fr++) begin
                logic kp;
                kp = keep_of(k, slow);
                send_frame(1'b0, -1, -1, 0, 0, 0, 0);
                chk(valid_cnt == (kp ? exp_n : 0), slow ? "R6" : "R5", "words per frame",
                    valid_cnt, kp ? exp_n : 0);
                chk(bad_blank == 0, "R3", "data while sync high", bad_blank, 0);
                chk(lat_err == 0, "R4", "latency/data mismatch", lat_err, 0);
                if (kp) begin
                    kept++;
                    chk(first_w == {8'h40 + 8'(pf), 8'h80 + 8'(lf)}, "R7", "first word",
                        first_w, {8'h40 + 8'(pf), 8'h80 + 8'(lf)});
                    chk(last_w == {8'h40 + 8'(pl), 8'h80 + 8'(ll)}, "R2", "last word",
                        last_w, {8'h40 + 8'(pl), 8'h80 + 8'(ll)});
                end
            end
            chk(kept == int'(v[3:0]), slow ? "R6" : "R5", "kept per 12", kept, int'(v[3:0]));
        end

        // R8 window change in mid-frame
        slow = 1'b0; lf = 0; ll = 5; pf = 0; pl = 11;
        align_even();
        send_frame(1'b0, -1, 2, 5'd1, 5'd1, 6'd3, 6'd3);
        chk(valid_cnt == ACT_L * ACT_P, "R8", "old window kept in frame", valid_cnt, ACT_L * ACT_P);
        send_frame(1'b0, -1, -1, 0, 0, 0, 0);
        send_frame(1'b0, -1, -1, 0, 0, 0, 0);
        chk(valid_cnt == 1, "R8", "new window next frame", valid_cnt, 1);
        chk(first_w == 16'h4381, "R8", "new window word", first_w, 16'h4381);

        // R1 corrupted SAV is ignored
        lf = 0; ll = 5; pf = 0; pl = 11;
        send_frame(1'b0, -1, -1, 0, 0, 0, 0);
        align_even();
        send_frame(1'b0, 1, -1, 0, 0, 0, 0);
        chk(valid_cnt == (ACT_L - 1) * ACT_P, "R1", "bad code line dropped", valid_cnt,
            (ACT_L - 1) * ACT_P);
        chk(last_w == 16'h4B85, "R1", "later lines intact", last_w, 16'h4B85);
        chk(lat_err == 0, "R1", "no code word leaked", lat_err, 0);

        // R9 field identity follows F at frame start
        align_even();
        send_frame(1'b1, -1, -1, 0, 0, 0, 0);
        chk(fid_o == 1'b1, "R9", "fid from F=1 frame", fid_o, 1);
        chk(fid_tog == 1, "R9", "fid changes once", fid_tog, 1);
        send_frame(1'b0, -1, -1, 0, 0, 0, 0);
        chk(fid_o == 1'b0 && fid_tog == 1, "R9", "fid back to 0", fid_o, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule